// File: doc/BRIEF.md
# Configurable serial character receiver

This block takes one serial line and rebuilds characters from it, one bit at a time on the rising edge of its receive clock. The finished character is handed to a CPU through a holding register that has a ready flag. In asynchronous mode each character is framed by a low start bit and one stop bit. The receive clock runs at 1, 16 or 64 times the bit rate. In the 16x and 64x settings the start bit must still be low at its mid-point, or the receiver drops it. In synchronous mode the clock runs at the bit rate. An external sync-detect input starts the receiver, and from then on characters follow each other with no framing bits.

A character is 5 to 8 data bits, sent least significant bit first, and may be followed by one even or odd parity bit. If a new character completes while the previous one is still unread, the new one replaces it and a sticky overrun flag is set. A parity mismatch sets a sticky parity flag. An error-reset pulse clears both flags. In asynchronous mode, a break output rises when the line is low at the stop-bit position of two characters in a row.

The configuration inputs are held stable outside reset. The active-low reset is asserted asynchronously and released synchronously inside the block.

Top module: `srx_top`

## Requirements
- R1: While reset is held and after it is released, rx_data is 0 and rx_ready, ovr_err, par_err and brk_det are low.
- R2: With cfg_sync=0 a frame is a low start bit, then 5+cfg_len data bits sent least significant bit first, then a parity bit when cfg_par_en=1, then one stop bit. cfg_factor selects the receive clocks per bit: 0 gives 1, 1 gives 16, 2 or 3 gives 64. rx_data bits above the character length read 0.
- R3: For factors 16 and 64, the line is sampled again half a bit time after it falls. A low pulse shorter than half a bit time produces no character.
- R4: rx_ready rises on the clock edge after the edge that samples the last bit of a character. A one-cycle rd_strobe clears it on the following edge, unless a character completes in that same cycle.
- R5: If a character completes while rx_ready is high and rd_strobe is low in that cycle, ovr_err is set and rx_data takes the newer character. A completion in the same cycle as rd_strobe sets no overrun and leaves rx_ready high.
- R6: ovr_err and par_err stay set until an err_clr pulse. A flag set in the same cycle as err_clr stays set.
- R7: With cfg_par_odd=0 the ones in the data bits plus the parity bit must be even. With cfg_par_odd=1 they must be odd. A mismatch sets par_err, and the character is still delivered.
- R8: With cfg_sync=0, brk_det goes high after two consecutive characters whose stop-bit sample is low. It returns low once the idle receiver sees the line high. With cfg_sync=1 it stays low.
- R9: With cfg_sync=1, rxd is ignored until sync_det is sampled high while the receiver is idle. The next edge after that samples the first data bit. Characters of 5+cfg_len data bits plus the optional parity bit then follow back to back, one bit per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; rxd is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cfg_sync | input | 1 | 1 selects external synchronous mode |
| cfg_factor | input | 2 | Clocks per bit in asynchronous mode: 0 gives 1, 1 gives 16, 2 or 3 gives 64 |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Enables the parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rxd | input | 1 | Serial data line |
| sync_det | input | 1 | In synchronous mode, a high level starts character assembly |
| rd_strobe | input | 1 | CPU read of the data register |
| err_clr | input | 1 | Clears the overrun and parity flags |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | A character is waiting to be read |
| ovr_err | output | 1 | Sticky overrun flag |
| par_err | output | 1 | Sticky parity flag |
| brk_det | output | 1 | Break detected on the line |

## Verification
Two pairs of events can land in the same clock cycle. A character can complete in the same cycle as a CPU read, and a new overrun can be raised in the same cycle as an error reset. The bench runs at one clock per bit, so it knows the exact cycle in which the stop bit is sampled. It times a one-cycle rd_strobe or err_clr to the following edge, which is the edge where the holding register loads. It then checks three outcomes: the read leaves rx_ready high with no overrun, the error reset leaves ovr_err set, and rx_data holds the newer character.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned MAX_BITS   = 8;
  localparam int unsigned MIN_BITS   = 5;
  localparam int unsigned MAX_FACTOR = 64;
  localparam int unsigned CNT_W      = $clog2(MAX_FACTOR);
  localparam int unsigned IDX_W      = $clog2(MAX_BITS + 2);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } rx_state_e;

  // Receive clocks per bit for the factor selector
  function automatic logic [CNT_W:0] factor_clocks(input logic [1:0] sel);
    case (sel)
      2'd0:    return (CNT_W+1)'(1);
      2'd1:    return (CNT_W+1)'(16);
      default: return (CNT_W+1)'(MAX_FACTOR);
    endcase
  endfunction
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler #(
  parameter int unsigned CW = srx_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          tick
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)                cnt_d = ld_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/srx_frame.sv
module srx_frame #(
  parameter int unsigned DW = srx_pkg::MAX_BITS,
  parameter int unsigned CW = srx_pkg::CNT_W,
  parameter int unsigned IW = srx_pkg::IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sync,
  input  logic [1:0]    cfg_factor,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          rxd,
  input  logic          sync_det,
  input  logic          tick,
  output logic          ld,
  output logic [CW-1:0] ld_val,
  output logic          done,
  output logic [DW-1:0] char_o,
  output logic          pbad_o,
  output logic          brk_o
);
  import srx_pkg::*;

  rx_state_e     st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] data_q, data_d, char_q, char_d;
  logic          pbad_q, pbad_d, cpar_q, cpar_d;
  logic          prev_low_q, prev_low_d, brk_q, brk_d, done_q, done_d;

  logic [CW:0]   fac;
  logic [CW-1:0] full_m1, half_m1;
  logic [IW-1:0] nbits, last_idx;
  logic          x1;

  assign fac      = factor_clocks(cfg_factor);
  assign x1       = (cfg_factor == 2'd0);
  assign full_m1  = cfg_sync ? '0 : CW'(fac - 1'b1);
  assign half_m1  = CW'((fac >> 1) - 1'b1);
  assign nbits    = IW'(MIN_BITS) + IW'(cfg_len);
  assign last_idx = nbits + IW'(cfg_par_en) + IW'(!cfg_sync) - IW'(1);

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    data_d     = data_q;
    pbad_d     = pbad_q;
    prev_low_d = prev_low_q;
    brk_d      = brk_q;
    done_d     = 1'b0;
    char_d     = char_q;
    cpar_d     = cpar_q;
    ld         = 1'b0;
    ld_val     = full_m1;
    unique case (st_q)
      ST_IDLE: begin
        if (cfg_sync) begin
          if (sync_det) begin
            st_d = ST_DATA; ld = 1'b1; ld_val = '0;
            idx_d = '0; data_d = '0; pbad_d = 1'b0;
          end
        end else if (!rxd) begin
          idx_d = '0; data_d = '0; pbad_d = 1'b0; ld = 1'b1;
          if (x1) begin
            st_d = ST_DATA; ld_val = '0;
          end else begin
            st_d = ST_START; ld_val = half_m1;
          end
        end else begin
          brk_d = 1'b0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (!rxd) begin
            st_d = ST_DATA; ld = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          ld = 1'b1;
          if (idx_q < nbits) begin
            for (int i = 0; i < int'(DW); i++) begin
              if (idx_q == IW'(i)) data_d[i] = rxd;
            end
          end
          if (cfg_par_en && (idx_q == nbits))
            pbad_d = rxd ^ (^data_q) ^ cfg_par_odd;
          if (!cfg_sync && (idx_q == last_idx)) begin
            if (!rxd) begin
              if (prev_low_q) brk_d = 1'b1;
              prev_low_d = 1'b1;
            end else begin
              prev_low_d = 1'b0;
            end
          end
          if (idx_q == last_idx) begin
            done_d = 1'b1;
            char_d = data_d;
            cpar_d = pbad_d;
            idx_d  = '0;
            data_d = '0;
            pbad_d = 1'b0;
            if (!cfg_sync) st_d = ST_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      data_q     <= '0;
      pbad_q     <= 1'b0;
      prev_low_q <= 1'b0;
      brk_q      <= 1'b0;
      done_q     <= 1'b0;
      char_q     <= '0;
      cpar_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      idx_q      <= idx_d;
      data_q     <= data_d;
      pbad_q     <= pbad_d;
      prev_low_q <= prev_low_d;
      brk_q      <= brk_d;
      done_q     <= done_d;
      char_q     <= char_d;
      cpar_q     <= cpar_d;
    end
  end

  assign done   = done_q;
  assign char_o = char_q;
  assign pbad_o = cpar_q;
  assign brk_o  = brk_q;
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int unsigned DW = srx_pkg::MAX_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_char,
  input  logic          load_pbad,
  input  logic          rd_strobe,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          ovr_err,
  output logic          par_err
);
  logic [DW-1:0] data_q, data_d;
  logic          rdy_q, rdy_d, ovr_q, ovr_d, par_q, par_d;

  always_comb begin
    data_d = load ? load_char : data_q;
    rdy_d  = load ? 1'b1 : (rd_strobe ? 1'b0 : rdy_q);
    if (load && rdy_q && !rd_strobe) ovr_d = 1'b1;
    else if (err_clr)                ovr_d = 1'b0;
    else                             ovr_d = ovr_q;
    if (load && load_pbad)           par_d = 1'b1;
    else if (err_clr)                par_d = 1'b0;
    else                             par_d = par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      ovr_q  <= ovr_d;
      par_q  <= par_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_ready = rdy_q;
  assign ovr_err  = ovr_q;
  assign par_err  = par_q;
endmodule

// File: rtl/srx_top.sv
module srx_top #(
  parameter int unsigned DW = srx_pkg::MAX_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sync,
  input  logic [1:0]    cfg_factor,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          rxd,
  input  logic          sync_det,
  input  logic          rd_strobe,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          ovr_err,
  output logic          par_err,
  output logic          brk_det
);
  localparam int unsigned CW = srx_pkg::CNT_W;

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic          smp_ld, smp_tick, frm_done, frm_pbad;
  logic [CW-1:0] smp_val;
  logic [DW-1:0] frm_char;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  srx_sampler #(.CW(CW)) i_sampler (
    .clk(clk), .rst_n(rst_int_n), .ld(smp_ld), .ld_val(smp_val), .tick(smp_tick)
  );

  srx_frame #(.DW(DW), .CW(CW)) i_frame (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_sync(cfg_sync), .cfg_factor(cfg_factor), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rxd(rxd), .sync_det(sync_det), .tick(smp_tick),
    .ld(smp_ld), .ld_val(smp_val),
    .done(frm_done), .char_o(frm_char), .pbad_o(frm_pbad), .brk_o(brk_det)
  );

  srx_hold #(.DW(DW)) i_hold (
    .clk(clk), .rst_n(rst_int_n),
    .load(frm_done), .load_char(frm_char), .load_pbad(frm_pbad),
    .rd_strobe(rd_strobe), .err_clr(err_clr),
    .rx_data(rx_data), .rx_ready(rx_ready), .ovr_err(ovr_err), .par_err(par_err)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_sync,
  input logic rd_strobe,
  input logic err_clr,
  input logic frm_done,
  input logic rx_ready,
  input logic ovr_err,
  input logic par_err,
  input logic brk_det
);
  a_r4_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> rx_ready);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && rd_strobe && !frm_done) |=> !rx_ready);

  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && rx_ready && !rd_strobe) |=> ovr_err);

  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !err_clr) |=> ovr_err);

  a_r6_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !frm_done) |=> (!ovr_err && !par_err));

  a_r8_no_break_sync: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sync |-> !brk_det);
endmodule

bind srx_top srx_chk i_chk (
  .clk(clk), .rst_n(rst_int_n), .cfg_sync(cfg_sync),
  .rd_strobe(rd_strobe), .err_clr(err_clr), .frm_done(frm_done),
  .rx_ready(rx_ready), .ovr_err(ovr_err), .par_err(par_err), .brk_det(brk_det)
);

// File: tb/test_srx_top.sv
module test_srx_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic       clk, rst_n, cfg_sync, cfg_par_en, cfg_par_odd;
  logic [1:0] cfg_factor, cfg_len;
  logic       rxd, sync_det, rd_strobe, err_clr;
  logic [7:0] rx_data;
  logic       rx_ready, ovr_err, par_err, brk_det;
  int         n_chk, n_fail;
  bit         finished;

  srx_top i_srx_top (
    .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_factor(cfg_factor),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rxd(rxd), .sync_det(sync_det), .rd_strobe(rd_strobe), .err_clr(err_clr),
    .rx_data(rx_data), .rx_ready(rx_ready), .ovr_err(ovr_err),
    .par_err(par_err), .brk_det(brk_det)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit sy, input int fs, input int ln, input bit pe, input bit po);
    rst_n = 1'b0; cfg_sync = sy; cfg_factor = 2'(fs); cfg_len = 2'(ln);
    cfg_par_en = pe; cfg_par_odd = po;
    rxd = 1'b1; sync_det = 1'b0; rd_strobe = 1'b0; err_clr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cpu_read();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic cpu_errclr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  // pm: 0 none, 1 even, 2 odd; pulse: 0 none, 1 read, 2 error reset at the load edge
  task automatic send_async(input logic [7:0] d, input int nb, input int f, input int pm,
                            input bit bad, input bit stopv, input int pulse, input bit ec);
    logic [7:0] m;
    logic       pb;
    m  = 8'((1 << nb) - 1);
    pb = 1'($countones(d & m) % 2);
    if (pm == 2) pb = ~pb;
    pb = pb ^ bad;
    rxd = 1'b0; repeat (f) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; repeat (f) @(negedge clk);
    end
    if (pm != 0) begin
      rxd = pb; repeat (f) @(negedge clk);
    end
    rxd = stopv; repeat (f) @(negedge clk);
    if (ec) chk(rx_ready == 1'b0, "R4 ready not yet up at stop-bit end", int'(rx_ready), 0);
    rxd = 1'b1;
    if (pulse == 1) rd_strobe = 1'b1;
    if (pulse == 2) err_clr = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; err_clr = 1'b0;
    if (ec) chk(rx_ready == 1'b1, "R4 ready one edge after last sample", int'(rx_ready), 1);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int v);
    case (v)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      default: return 8'h3C;
    endcase
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [17:0] stream;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; rxd = 1'b1; sync_det = 1'b0; rd_strobe = 1'b0; err_clr = 1'b0;
    cfg_sync = 1'b0; cfg_factor = 2'd0; cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    // R2 sweep over factor, length and parity mode
    for (int fs = 0; fs < 3; fs++) begin
      for (int ln = 0; ln < 4; ln++) begin
        for (int pm = 0; pm < 3; pm++) begin
          do_reset(1'b0, fs, ln, pm != 0, pm == 2);
          if (fs == 0 && ln == 0 && pm == 0) begin
            chk(rx_data == 8'h00, "R1 data after reset", int'(rx_data), 0);
            chk(rx_ready == 1'b0, "R1 ready after reset", int'(rx_ready), 0);
            chk(ovr_err == 1'b0, "R1 overrun after reset", int'(ovr_err), 0);
            chk(par_err == 1'b0, "R1 parity after reset", int'(par_err), 0);
            chk(brk_det == 1'b0, "R1 break after reset", int'(brk_det), 0);
          end
          for (int v = 0; v < 256; v++) begin
            logic [7:0] d;
            int nb, f, expv;
            if (fs != 0 && v >= 4) break;
            d    = (fs == 0) ? 8'(v) : pat(v);
            nb   = 5 + ln;
            f    = (fs == 0) ? 1 : ((fs == 1) ? 16 : 64);
            expv = int'(d) & ((1 << nb) - 1);
            send_async(d, nb, f, pm, 1'b0, 1'b1, 0, fs == 0);
            chk(int'(rx_data) == expv, "R2 received character", int'(rx_data), expv);
            chk(rx_ready == 1'b1, "R2 ready after frame", int'(rx_ready), 1);
            chk(par_err == 1'b0, "R7 correct parity gives no error", int'(par_err), 0);
            cpu_read();
            chk(rx_ready == 1'b0, "R4 read clears ready", int'(rx_ready), 0);
          end
        end
      end
    end

    // R5 and R6: overrun, same-cycle read, same-cycle error reset
    do_reset(1'b0, 0, 3, 1'b0, 1'b0);
    send_async(8'h11, 8, 1, 0, 1'b0, 1'b1, 0, 1'b0);
    send_async(8'h22, 8, 1, 0, 1'b0, 1'b1, 0, 1'b0);
    chk(ovr_err == 1'b1, "R5 overrun on unread character", int'(ovr_err), 1);
    chk(rx_data == 8'h22, "R5 newer character kept", int'(rx_data), 'h22);
    cpu_errclr();
    chk(ovr_err == 1'b0, "R6 error reset clears overrun", int'(ovr_err), 0);
    send_async(8'h33, 8, 1, 0, 1'b0, 1'b1, 1, 1'b0);
    chk(ovr_err == 1'b0, "R5 read in load cycle gives no overrun", int'(ovr_err), 0);
    chk(rx_ready == 1'b1, "R5 ready stays with read in load cycle", int'(rx_ready), 1);
    chk(rx_data == 8'h33, "R5 data with read in load cycle", int'(rx_data), 'h33);
    send_async(8'h44, 8, 1, 0, 1'b0, 1'b1, 2, 1'b0);
    chk(ovr_err == 1'b1, "R6 overrun set wins over error reset", int'(ovr_err), 1);
    repeat (10) @(negedge clk);
    cpu_read();
    chk(ovr_err == 1'b1, "R6 overrun survives read", int'(ovr_err), 1);
    cpu_errclr();
    chk(ovr_err == 1'b0, "R6 overrun cleared", int'(ovr_err), 0);

    // R7 parity errors
    do_reset(1'b0, 0, 3, 1'b1, 1'b0);
    send_async(8'h0F, 8, 1, 1, 1'b1, 1'b1, 0, 1'b0);
    chk(par_err == 1'b1, "R7 even parity mismatch", int'(par_err), 1);
    chk(rx_data == 8'h0F, "R7 character delivered despite mismatch", int'(rx_data), 'h0F);
    cpu_read();
    send_async(8'h01, 8, 1, 1, 1'b0, 1'b1, 0, 1'b0);
    chk(par_err == 1'b1, "R6 parity flag sticky", int'(par_err), 1);
    cpu_errclr();
    chk(par_err == 1'b0, "R6 parity flag cleared", int'(par_err), 0);
    do_reset(1'b0, 0, 0, 1'b1, 1'b1);
    send_async(8'h15, 5, 1, 2, 1'b1, 1'b1, 0, 1'b0);
    chk(par_err == 1'b1, "R7 odd parity mismatch", int'(par_err), 1);

    // R3 short low pulses are dropped
    do_reset(1'b0, 1, 3, 1'b0, 1'b0);
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk(rx_ready == 1'b0, "R3 x16 glitch ignored", int'(rx_ready), 0);
    send_async(8'hC3, 8, 16, 0, 1'b0, 1'b1, 0, 1'b0);
    chk(rx_data == 8'hC3, "R3 valid frame after glitch", int'(rx_data), 'hC3);
    do_reset(1'b0, 2, 3, 1'b0, 1'b0);
    rxd = 1'b0; repeat (30) @(negedge clk); rxd = 1'b1;
    repeat (100) @(negedge clk);
    chk(rx_ready == 1'b0, "R3 x64 glitch ignored", int'(rx_ready), 0);

    // R8 break detection
    do_reset(1'b0, 1, 3, 1'b0, 1'b0);
    rxd = 1'b0;
    repeat (160) @(negedge clk);
    chk(brk_det == 1'b0, "R8 no break after one low stop bit", int'(brk_det), 0);
    repeat (170) @(negedge clk);
    chk(brk_det == 1'b1, "R8 break after two low stop bits", int'(brk_det), 1);
    chk(rx_data == 8'h00, "R8 break character is zero", int'(rx_data), 0);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk(brk_det == 1'b0, "R8 break clears on idle high line", int'(brk_det), 0);

    // R9 synchronous mode with external sync detect
    do_reset(1'b1, 0, 3, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) begin
      rxd = 1'(i); @(negedge clk);
    end
    chk(rx_ready == 1'b0, "R9 line ignored before sync detect", int'(rx_ready), 0);
    stream = {1'b0, 8'h5A, 1'b0, 8'h00};
    sync_det = 1'b1; @(negedge clk); sync_det = 1'b0;
    for (int i = 0; i < 18; i++) begin
      if (i == 10) begin
        chk(rx_ready == 1'b1, "R9 first character ready", int'(rx_ready), 1);
        chk(rx_data == 8'h00, "R9 first character value", int'(rx_data), 0);
      end
      rxd = stream[i]; @(negedge clk);
    end
    rxd = 1'b1; @(negedge clk);
    chk(rx_data == 8'h5A, "R9 second character back to back", int'(rx_data), 'h5A);
    chk(ovr_err == 1'b1, "R5 overrun in synchronous mode", int'(ovr_err), 1);
    chk(par_err == 1'b0, "R7 synchronous parity good", int'(par_err), 0);
    chk(brk_det == 1'b0, "R8 no break in synchronous mode", int'(brk_det), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule